// File: doc/BRIEF.md
# Scatter-Gather Fetch-Size Bucket Mapper

This block picks how much of a command a DMA engine should fetch from host memory. It keeps eight programmable fetch sizes ("buckets"), each counted in 16-byte blocks. From those sizes it keeps a lookup map with one entry for every scatter-gather (SG) element count from zero up to a configured maximum. Each entry names the smallest-index bucket that can hold a command with that many SG elements. A command with `n` SG elements needs `n + 4` blocks, so even a command with no SG elements needs four.

On each submit the block takes a 32-byte-aligned command address, the command's SG count and its command index. One clock later it returns the address with its five free low bits encoded, together with a direct-lookup tag word built from the index. When the enhanced transport is selected, bit 0 of the returned address is set and the bucket number sits in bits 3..1. When it is not selected, the low bits stay clear. Writing any bucket size starts a rebuild of the map, which handles one SG count per clock. Submits are refused while `busy` is high.

Top module: `sg_fetch_mapper`

## Requirements
- R1: After reset the bucket sizes, by bucket index 0..7, are 5, 6, 8, 10, 12, 20, 28 and MAX_SG+4 (36 with the default MAX_SG of 32).
- R2: For an accepted submit with SG count `n` (0..MAX_SG), the chosen bucket is the lowest index `j` whose size is at least `n + 4`.
- R3: With `enhMode` high, the returned address has bit 0 = 1, bits 3..1 = chosen bucket index, bit 4 = 0, and bits 31..5 equal to those of `subAddr`.
- R4: When several buckets fit, the lowest index wins, even when the sizes are not in ascending order.
- R5: `busy` is high from reset, and for MAX_SG+1 (33) clocks after the edge that takes a bucket write. A write made during a rebuild restarts the full count.
- R6: With `enhMode` low, the returned address has bits 4..0 = 0 and bits 31..5 equal to those of `subAddr`.
- R7: Bits 4..0 of `subAddr` have no effect on the output.
- R8: A submit offered while `busy` is high is dropped, and no `outValid` pulse follows it.
- R9: If no bucket size reaches `n + 4`, `outNoFit` is 1 and the bucket field (bits 3..1) is 0. Bit 0 still follows `enhMode`.
- R10: An SG count above MAX_SG always gives `outNoFit` = 1.
- R11: `outTag` equals `subCmdIdx` shifted left by 5 with bit 4 set (bits 3..0 are 0).
- R12: `outValid` pulses for exactly one clock, on the edge after each accepted submit, and the output fields are valid in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write one bucket size |
| cfgWrSel | input | 3 | Bucket index to write |
| cfgWrSize | input | 8 | New bucket size in 16-byte blocks |
| enhMode | input | 1 | Enhanced transport selected: encode low address bits |
| subValid | input | 1 | Submit request |
| subAddr | input | 32 | Command address (32-byte aligned) |
| subSgCnt | input | 6 | SG element count of the command |
| subCmdIdx | input | 11 | Command index for the tag |
| busy | output | 1 | Map rebuild in progress; submits refused |
| outValid | output | 1 | Encoded result valid |
| outAddr | output | 32 | Encoded command address |
| outTag | output | 16 | Direct-lookup tag word |
| outNoFit | output | 1 | No bucket large enough |

## Verification
The first sweep submits every SG count from 0 to 32 with the reset sizes. It shows whether each bucket boundary (counts 1, 2, 4, 6, 8, 16, 24, 32) is placed one block too early or too late. The bench then rewrites the sizes out of order, with a large bucket 0, which separates a lowest-index search from a best-size search. It also shrinks the top buckets so that no-fit entries appear. Submits issued during a rebuild, with the enhanced mode toggled, and with dirty low address bits show apart the gating, the two encodings and the masking. Out-of-range SG counts and extreme command indices exercise the no-fit path and the tag packing.

// File: rtl/sgb_pkg.sv
`timescale 1ns/1ps
package sgb_pkg;

  // Strobes sent from control to datapath each cycle.
  typedef struct packed {
    logic mapWrite;   // store the search result for the current rebuild pointer
    logic accept;     // register a submit result
  } sgb_strobe_t;

  // Reset size of bucket idx, in 16-byte blocks; the last bucket covers the largest command.
  function automatic int defaultBucket(int idx, int numBuckets, int maxSg, int minBlocks);
    if (idx == numBuckets - 1) return maxSg + minBlocks;
    case (idx)
      0: return 5;
      1: return 6;
      2: return 8;
      3: return 10;
      4: return 12;
      5: return 20;
      6: return 28;
      default: return maxSg + minBlocks;
    endcase
  endfunction

endpackage

// File: rtl/sgb_ctrl.sv
`timescale 1ns/1ps
module sgb_ctrl
  import sgb_pkg::*;
#(
  parameter int MAX_SG = 32,
  parameter int SG_W   = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic            subValid,
  output sgb_strobe_t     strb,
  output logic [SG_W-1:0] mapPtr,
  output logic            busy
);

  logic            busyQ;
  logic [SG_W-1:0] ptrQ;

  // Rebuild walks SG counts 0..MAX_SG, one per clock; a bucket write restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b1;
      ptrQ  <= '0;
    end else if (cfgWrEn) begin
      busyQ <= 1'b1;
      ptrQ  <= '0;
    end else if (busyQ) begin
      if (ptrQ == SG_W'(MAX_SG)) begin
        busyQ <= 1'b0;
      end else begin
        ptrQ <= ptrQ + 1'b1;
      end
    end
  end

  always_comb begin
    strb.mapWrite = busyQ && !cfgWrEn;
    strb.accept   = subValid && !busyQ;
  end

  assign mapPtr = ptrQ;
  assign busy   = busyQ;

endmodule

// File: rtl/sgb_datapath.sv
`timescale 1ns/1ps
module sgb_datapath
  import sgb_pkg::*;
#(
  parameter int NUM_BUCKETS = 8,
  parameter int MAX_SG      = 32,
  parameter int MIN_BLOCKS  = 4,
  parameter int SIZE_W      = 8,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 11,
  parameter int SG_W        = 6,
  parameter int SEL_W       = 3,
  parameter int TAG_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sgb_strobe_t       strb,
  input  logic [SG_W-1:0]   mapPtr,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgWrSel,
  input  logic [SIZE_W-1:0] cfgWrSize,
  input  logic              enhMode,
  input  logic [ADDR_W-1:0] subAddr,
  input  logic [SG_W-1:0]   subSgCnt,
  input  logic [IDX_W-1:0]  subCmdIdx,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [TAG_W-1:0]  outTag,
  output logic              outNoFit
);

  localparam int BKT_W   = $clog2(NUM_BUCKETS + 1);
  localparam int ALIGN_W = 5;

  logic [SIZE_W-1:0] bucket [NUM_BUCKETS];
  logic [BKT_W-1:0]  fitMap [MAX_SG+1];
  logic [SIZE_W:0]   need;
  logic [NUM_BUCKETS-1:0] fits;
  logic [BKT_W-1:0]  fitIdx;

  // Bucket size registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < NUM_BUCKETS; j++)
        bucket[j] <= SIZE_W'(defaultBucket(j, NUM_BUCKETS, MAX_SG, MIN_BLOCKS));
    end else if (cfgWrEn) begin
      bucket[cfgWrSel] <= cfgWrSize;
    end
  end

  // Blocks needed by a command whose SG count is the rebuild pointer.
  assign need = (SIZE_W+1)'(mapPtr) + (SIZE_W+1)'(MIN_BLOCKS);

  for (genvar g = 0; g < NUM_BUCKETS; g++) begin : gFit
    assign fits[g] = {1'b0, bucket[g]} >= need;
  end

  // Lowest fitting index; NUM_BUCKETS when none fits.
  always_comb begin
    fitIdx = BKT_W'(NUM_BUCKETS);
    for (int j = NUM_BUCKETS - 1; j >= 0; j--)
      if (fits[j]) fitIdx = BKT_W'(j);
  end

  always_ff @(posedge clk) begin
    if (strb.mapWrite) fitMap[mapPtr] <= fitIdx;
  end

  // Submit lookup and encoding.
  logic             overMax;
  logic [SG_W-1:0]  safeIdx;
  logic [BKT_W-1:0] lookIdx;
  logic             noFit;
  logic [SEL_W-1:0] field;
  logic [ALIGN_W-1:0] lowBits;

  always_comb begin
    overMax = subSgCnt > SG_W'(MAX_SG);
    safeIdx = overMax ? '0 : subSgCnt;
    lookIdx = overMax ? BKT_W'(NUM_BUCKETS) : fitMap[safeIdx];
    noFit   = lookIdx == BKT_W'(NUM_BUCKETS);
    field   = noFit ? '0 : lookIdx[SEL_W-1:0];
    lowBits = enhMode ? ALIGN_W'({field, 1'b1}) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outTag   <= '0;
      outNoFit <= 1'b0;
    end else begin
      outValid <= strb.accept;
      if (strb.accept) begin
        outAddr  <= (subAddr & ~ADDR_W'((1 << ALIGN_W) - 1)) | ADDR_W'(lowBits);
        outTag   <= {subCmdIdx, 1'b1, 4'b0000};
        outNoFit <= noFit;
      end
    end
  end

endmodule

// File: rtl/sg_fetch_mapper.sv
`timescale 1ns/1ps
module sg_fetch_mapper
  import sgb_pkg::*;
#(
  parameter int NUM_BUCKETS = 8,
  parameter int MAX_SG      = 32,
  parameter int MIN_BLOCKS  = 4,
  parameter int SIZE_W      = 8,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 11,
  localparam int SG_W       = $clog2(MAX_SG + 1),
  localparam int SEL_W      = $clog2(NUM_BUCKETS),
  localparam int TAG_W      = IDX_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgWrSel,
  input  logic [SIZE_W-1:0] cfgWrSize,
  input  logic              enhMode,
  input  logic              subValid,
  input  logic [ADDR_W-1:0] subAddr,
  input  logic [SG_W-1:0]   subSgCnt,
  input  logic [IDX_W-1:0]  subCmdIdx,
  output logic              busy,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [TAG_W-1:0]  outTag,
  output logic              outNoFit
);

  sgb_strobe_t     strb;
  logic [SG_W-1:0] mapPtr;

  sgb_ctrl #(.MAX_SG(MAX_SG), .SG_W(SG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .subValid(subValid),
    .strb(strb), .mapPtr(mapPtr), .busy(busy)
  );

  sgb_datapath #(
    .NUM_BUCKETS(NUM_BUCKETS), .MAX_SG(MAX_SG), .MIN_BLOCKS(MIN_BLOCKS),
    .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SG_W(SG_W),
    .SEL_W(SEL_W), .TAG_W(TAG_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mapPtr(mapPtr),
    .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrSize(cfgWrSize),
    .enhMode(enhMode), .subAddr(subAddr), .subSgCnt(subSgCnt),
    .subCmdIdx(subCmdIdx), .outValid(outValid), .outAddr(outAddr),
    .outTag(outTag), .outNoFit(outNoFit)
  );

endmodule

// File: rtl/sg_fetch_mapper_chk.sv
`timescale 1ns/1ps
module sg_fetch_mapper_chk #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              enhMode,
  input logic              subValid,
  input logic              busy,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic [TAG_W-1:0]  outTag,
  input logic              outNoFit
);

  a_r8_busy_drops_submit: assert property (@(posedge clk) disable iff (!rstN)
    (busy && subValid) |=> !outValid);

  a_r5_write_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> busy);

  a_r12_accept_gives_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && !busy) |=> outValid);

  a_r3_enh_mark_bit: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(enhMode)) |-> (outAddr[0] && !outAddr[4]));

  a_r6_plain_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(enhMode)) |-> (outAddr[4:0] == 5'b0));

  a_r11_tag_marker: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outTag[4:0] == 5'b10000));

  a_r9_nofit_field_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outNoFit) |-> (outAddr[3:1] == 3'b000));

endmodule

bind sg_fetch_mapper sg_fetch_mapper_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .enhMode(enhMode),
  .subValid(subValid), .busy(busy), .outValid(outValid), .outAddr(outAddr),
  .outTag(outTag), .outNoFit(outNoFit)
);

// File: tb/sg_fetch_mapper_tb_top.sv
`timescale 1ns/1ps
module sg_fetch_mapper_tb_top;

  localparam int NB = 8, MAXSG = 32, ADDRW = 32, IDXW = 11, TAGW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic             cfgWrEn = 0;
  logic [2:0]       cfgWrSel = 0;
  logic [7:0]       cfgWrSize = 0;
  logic             enhMode = 0;
  logic             subValid = 0;
  logic [ADDRW-1:0] subAddr = 0;
  logic [5:0]       subSgCnt = 0;
  logic [IDXW-1:0]  subCmdIdx = 0;
  logic             busy, outValid, outNoFit;
  logic [ADDRW-1:0] outAddr;
  logic [TAGW-1:0]  outTag;

  sg_fetch_mapper dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrSize(cfgWrSize), .enhMode(enhMode), .subValid(subValid),
    .subAddr(subAddr), .subSgCnt(subSgCnt), .subCmdIdx(subCmdIdx),
    .busy(busy), .outValid(outValid), .outAddr(outAddr), .outTag(outTag),
    .outNoFit(outNoFit)
  );

  int    vectors = 0, miscompares = 0, cycles = 0;
  bit    started = 0, done = 0;
  string curReq = "R5";

  // Reference model state
  int               bkt [NB];
  int               busyLeft = 0;
  bit               expValid = 0, expNoFit = 0, expEnh = 0, accM;
  logic [ADDRW-1:0] expAddr = 0;
  logic [TAGW-1:0]  expTag = 0;
  int               fitM;

  function automatic int bestFit(int sg);
    if (sg > MAXSG) return NB;
    for (int j = 0; j < NB; j++) if (bkt[j] >= sg + 4) return j;
    return NB;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      bkt = '{5, 6, 8, 10, 12, 20, 28, MAXSG + 4};
      busyLeft = MAXSG + 1;
      expValid = 0;
    end else begin
      accM = subValid && (busyLeft == 0);
      expValid = accM;
      if (accM) begin
        fitM = bestFit(int'(subSgCnt));
        expNoFit = (fitM == NB);
        expEnh = enhMode;
        expAddr = subAddr & ~32'h1F;
        if (enhMode) expAddr = expAddr | ((expNoFit ? 0 : fitM) << 1) | 1;
        expTag = TAGW'((int'(subCmdIdx) << 5) | 16);
      end
      if (cfgWrEn) begin
        bkt[cfgWrSel] = int'(cfgWrSize);
        busyLeft = MAXSG + 1;
      end else if (busyLeft > 0) begin
        busyLeft--;
      end
    end
  end

  task automatic fail(string what, longint act, longint exp);
    miscompares++;
    $display("FAIL %s [%s] actual=%0h expected=%0h", what, curReq, act, exp);
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (busy !== (busyLeft > 0)) fail("R5 busy", busy, busyLeft > 0);
      if (outValid !== expValid) fail("R12 R8 outValid", outValid, expValid);
      if (expValid && outValid) begin
        if (outAddr !== expAddr) fail(expEnh ? "R3 outAddr" : "R6 outAddr", outAddr, expAddr);
        if (outTag !== expTag) fail("R11 outTag", outTag, expTag);
        if (outNoFit !== expNoFit) fail("R9 R10 outNoFit", outNoFit, expNoFit);
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      miscompares++;
      $display("FAIL R12 watchdog expired actual=%0d expected=<20000", cycles);
      summary();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sub(int sg, logic [ADDRW-1:0] a, int idx);
    subValid = 1; subSgCnt = 6'(sg); subAddr = a; subCmdIdx = IDXW'(idx);
    @(negedge clk);
    subValid = 0;
  endtask

  task automatic wr(int sel, int size);
    cfgWrEn = 1; cfgWrSel = 3'(sel); cfgWrSize = 8'(size);
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 R5: reset sizes, initial rebuild window
    curReq = "R1 R5";
    idle(36);
    // R2 R3 R11: sweep every SG count with enhanced encoding
    curReq = "R2 R3 R11";
    enhMode = 1;
    for (int sg = 0; sg <= MAXSG; sg++) sub(sg, 32'h4000_0000 + (sg << 5), sg);
    idle(2);
    // R6: plain transport
    curReq = "R6";
    enhMode = 0;
    sub(0, 32'h0000_0100, 1);
    sub(20, 32'hFFFF_FFE0, 2);
    sub(32, 32'h8765_4320, 3);
    // R7: dirty low address bits
    curReq = "R7";
    sub(7, 32'h1234_567F, 4);
    enhMode = 1;
    sub(3, 32'hABCD_EF1F, 5);
    sub(12, 32'h0000_0015, 6);
    // R8 R5: submits during rebuild, rebuild restart
    curReq = "R8 R5";
    wr(2, 9);
    for (int k = 0; k < 5; k++) sub(k, 32'h2000_0000, k);
    idle(4);
    wr(3, 11);
    sub(6, 32'h2000_0040, 9);
    idle(34);
    sub(5, 32'h2000_0080, 10);
    // R4: lowest index wins with unordered sizes
    curReq = "R4";
    wr(0, 40);
    idle(34);
    sub(0, 32'h3000_0000, 11);
    sub(20, 32'h3000_0020, 12);
    sub(32, 32'h3000_0040, 13);
    // R9: no bucket large enough
    curReq = "R9";
    wr(0, 5);
    wr(7, 20);
    wr(6, 10);
    idle(34);
    sub(25, 32'h5000_0000, 14);
    sub(30, 32'h5000_0020, 15);
    sub(16, 32'h5000_0040, 16);
    sub(10, 32'h5000_0060, 17);
    // R10: counts above the maximum
    curReq = "R10";
    sub(33, 32'h6000_0000, 18);
    sub(63, 32'h6000_0020, 19);
    // R11: tag packing at the index limits
    curReq = "R11";
    sub(1, 32'h7000_0000, 0);
    sub(1, 32'h7000_0020, 2047);
    sub(1, 32'h7000_0040, 1234);
    idle(3);
    summary();
  end

endmodule